// File: doc/BRIEF.md
# Lockable Identification Page Controller

This block owns a single extra page of storage, separate from the main memory array. Software on the bus can fill it with board-specific values and then freeze it forever. It sits behind a serial slave front end, which has already turned bus activity into Start and Stop event pulses, received-byte strobes and read-byte requests. The block parses the command bytes itself: a device byte that carries a 4-bit type code, a chip select and a direction bit, then two address bytes, then data. It returns one acknowledge decision for every received byte. The front end drives that decision onto the bus.

Four operations share this framing. The first is a write into the page, with address bit 10 clear. The second is a read from the page, starting either at the current pointer or after a dummy write that sets the pointer. The third is a lock command, with address bit 10 set and a single data byte. The fourth is a lock-status query: this is the lock command cut short by a new Start. The lock bit is a register that is cleared only by reset, and it stands in for non-volatile storage. Once the lock bit is set, page writes are refused. A write-protect input blocks both storing data and locking.

Top module: `idpage_ctrl`

## Requirements
- R1: After reset, ack_vld_o and rd_vld_o are low, the page is unlocked, and every page byte reads as 8'h00.
- R2: Each byte strobe produces exactly one ack_vld_o pulse on the next cycle. The device byte is acknowledged only when bits 7:4 equal 4'b1011 and bits 3:1 equal chip_sel_i. A device byte that fails this check is refused, and so is every later byte until the next Start.
- R3: Both address bytes are acknowledged. The page pointer takes its value from bits 6:0 of the second address byte. In the first address byte, every bit except bit 2 (address bit 10) is ignored.
- R4: In a page write (address bit 10 = 0, unlocked), each data byte is acknowledged and stored at the pointer. The pointer then advances, and it wraps from 127 to 0 within the page.
- R5: In a read (device byte bit 0 = 1), each rd_req_i returns the byte at the pointer on rd_data_o, with rd_vld_o high, on the next cycle. The pointer advances with the same wrap within the page.
- R6: In a lock-form command (address bit 10 = 1), the first data byte is acknowledged while unlocked and refused while locked. Any further data bytes are refused.
- R7: The page locks at the Stop that ends a lock-form command, provided its data byte had bit 1 set (all other bits ignored), the page was unlocked, and wp_i is low at that Stop. A lock data byte with bit 1 clear, or a Start before the Stop, leaves the page unlocked. The lock never clears until reset.
- R8: While locked, page-write data bytes are refused and page contents are unchanged.
- R9: While wp_i is high, page-write data bytes are acknowledged but not stored, and a lock command has no effect.
- R10: rd_req_i outside a read transaction produces no rd_vld_o pulse.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low reset; also clears the lock |
| chip_sel_i | input | 3 | Strapped chip-select value compared with device byte bits 3:1 |
| wp_i | input | 1 | Write protect; high blocks page stores and locking |
| start_i | input | 1 | One-cycle pulse for a bus Start or repeated Start |
| stop_i | input | 1 | One-cycle pulse for a bus Stop |
| byte_vld_i | input | 1 | One-cycle strobe: byte_i holds a byte received from the master |
| byte_i | input | 8 | Received byte |
| rd_req_i | input | 1 | One-cycle request for the next byte to send to the master |
| ack_vld_o | output | 1 | Acknowledge decision valid, one cycle after byte_vld_i |
| ack_o | output | 1 | 1 = acknowledge, 0 = refuse |
| rd_vld_o | output | 1 | Read data valid, one cycle after an accepted rd_req_i |
| rd_data_o | output | 8 | Byte read from the page |

## Verification
The assertions assume the front end never raises more than one of start_i, stop_i, byte_vld_i and rd_req_i in the same cycle. They also assume it only requests read bytes while the master is reading. The bench drives each event as a single-cycle pulse followed by an idle cycle, so no two events ever overlap. It issues rd_req_i outside a read only in the deliberate R10 case. Lock-status queries are always closed with a Start and then a Stop, which matches how the query is meant to be discarded.

// File: rtl/idp_pkg.sv
package idp_pkg;

    typedef enum logic [2:0] {
        ST_IGNORE,   // not addressed; refuse bytes until next Start
        ST_DEVICE,   // expecting device byte
        ST_ADDR_HI,  // expecting high address byte
        ST_ADDR_LO,  // expecting low address byte
        ST_WR_DATA,  // page write data
        ST_LK_DATA,  // lock-form data byte
        ST_LK_END,   // lock-form complete, waiting for Stop
        ST_READ      // master is reading
    } idp_state_e;

endpackage

// File: rtl/idp_page_store.sv
module idp_page_store #(
    parameter int PAGE_BYTES = 128,
    parameter int PTR_W      = $clog2(PAGE_BYTES)
) (
    input  logic             clk_i,
    input  logic             rst_ni,
    input  logic             we_i,
    input  logic             rd_en_i,
    input  logic [PTR_W-1:0] addr_i,
    input  logic [7:0]       wdata_i,
    output logic             rd_vld_o,
    output logic [7:0]       rd_data_o
);

    typedef struct packed {
        logic       rd_vld;
        logic [7:0] rd_data;
    } store_t;

    store_t     q, d;
    logic [7:0] mem_q [PAGE_BYTES];

    always_comb begin
        d         = q;
        d.rd_vld  = rd_en_i;
        if (rd_en_i) begin
            d.rd_data = mem_q[addr_i];
        end
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            q <= '0;
            for (int i = 0; i < PAGE_BYTES; i++) begin
                mem_q[i] <= '0;
            end
        end else begin
            q <= d;
            if (we_i) begin
                mem_q[addr_i] <= wdata_i;
            end
        end
    end

    assign rd_vld_o  = q.rd_vld;
    assign rd_data_o = q.rd_data;

    // R5: a read enable yields valid data on the following cycle
    p_rd_vld_follows_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
        rd_en_i |=> rd_vld_o);
    // R10: no read enable, no valid data
    p_rd_vld_quiet_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
        !rd_en_i |=> !rd_vld_o);
    // R5: data holds between reads
    p_rd_data_hold_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
        !rd_en_i |=> $stable(rd_data_o));

endmodule

// File: rtl/idp_cmd_fsm.sv
module idp_cmd_fsm
    import idp_pkg::*;
#(
    parameter int         PAGE_BYTES    = 128,
    parameter logic [3:0] TYPE_NIBBLE   = 4'b1011,
    parameter int         LOCK_ADDR_BIT = 10,
    parameter int         LOCK_DATA_BIT = 1,
    parameter int         PTR_W         = $clog2(PAGE_BYTES)
) (
    input  logic             clk_i,
    input  logic             rst_ni,
    input  logic [2:0]       chip_sel_i,
    input  logic             wp_i,
    input  logic             start_i,
    input  logic             stop_i,
    input  logic             byte_vld_i,
    input  logic [7:0]       byte_i,
    input  logic             rd_req_i,
    output logic             ack_vld_o,
    output logic             ack_o,
    output logic             mem_we_o,
    output logic             mem_rd_o,
    output logic [PTR_W-1:0] ptr_o
);

    // position of the lock-select address bit inside the high address byte
    localparam int               HI_LOCK_POS = LOCK_ADDR_BIT - 8;
    localparam logic [PTR_W-1:0] PTR_ONE     = 1;

    typedef struct packed {
        idp_state_e       st;
        logic [PTR_W-1:0] ptr;
        logic             lock_form;
        logic             pend_lock;
        logic             locked;
        logic             ack_vld;
        logic             ack;
    } ctl_t;

    ctl_t q, d;
    logic we_d, rd_d;

    always_comb begin
        d         = q;
        d.ack_vld = 1'b0;
        d.ack     = 1'b0;
        we_d      = 1'b0;
        rd_d      = 1'b0;

        if (start_i) begin
            d.st        = ST_DEVICE;
            d.pend_lock = 1'b0;
        end else if (stop_i) begin
            if (q.st == ST_LK_END && q.pend_lock && !wp_i) begin
                d.locked = 1'b1;
            end
            d.st        = ST_IGNORE;
            d.pend_lock = 1'b0;
        end else if (byte_vld_i) begin
            d.ack_vld = 1'b1;
            unique case (q.st)
                ST_DEVICE: begin
                    if (byte_i[7:4] == TYPE_NIBBLE && byte_i[3:1] == chip_sel_i) begin
                        d.ack = 1'b1;
                        d.st  = byte_i[0] ? ST_READ : ST_ADDR_HI;
                    end else begin
                        d.st  = ST_IGNORE;
                    end
                end
                ST_ADDR_HI: begin
                    d.ack       = 1'b1;
                    d.lock_form = byte_i[HI_LOCK_POS];
                    d.st        = ST_ADDR_LO;
                end
                ST_ADDR_LO: begin
                    d.ack = 1'b1;
                    d.ptr = byte_i[PTR_W-1:0];
                    d.st  = q.lock_form ? ST_LK_DATA : ST_WR_DATA;
                end
                ST_WR_DATA: begin
                    if (!q.locked) begin
                        d.ack = 1'b1;
                        we_d  = !wp_i;
                        d.ptr = q.ptr + PTR_ONE;
                    end
                end
                ST_LK_DATA: begin
                    d.ack       = !q.locked;
                    d.pend_lock = !q.locked && byte_i[LOCK_DATA_BIT];
                    d.st        = ST_LK_END;
                end
                default: begin
                    d.ack = 1'b0;
                end
            endcase
        end else if (rd_req_i && q.st == ST_READ) begin
            rd_d  = 1'b1;
            d.ptr = q.ptr + PTR_ONE;
        end
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            q    <= '0;
            q.st <= ST_IGNORE;
        end else begin
            q <= d;
        end
    end

    assign ack_vld_o = q.ack_vld;
    assign ack_o     = q.ack;
    assign mem_we_o  = we_d;
    assign mem_rd_o  = rd_d;
    assign ptr_o     = q.ptr;

    // R2: one decision per received byte, on the next cycle
    p_ack_per_byte_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (byte_vld_i && !start_i && !stop_i) |=> ack_vld_o);
    p_no_spurious_ack_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
        !byte_vld_i |=> !ack_vld_o);
    // R7: lock is sticky and only appears right after a Stop
    p_lock_sticky_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
        q.locked |=> q.locked);
    p_lock_at_stop_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
        $rose(q.locked) |-> $past(stop_i));
    // R8: locked page write data is refused
    p_locked_wr_nack_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (q.st == ST_WR_DATA && q.locked && byte_vld_i && !start_i && !stop_i)
            |=> (ack_vld_o && !ack_o));
    // R9: nothing is stored while write-protected
    p_wp_no_store_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
        wp_i |-> !mem_we_o);
    // R7: write-protect at the Stop prevents locking
    p_wp_no_lock_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (wp_i && !q.locked) |=> !q.locked);

endmodule

// File: rtl/idpage_ctrl.sv
module idpage_ctrl #(
    parameter int         PAGE_BYTES    = 128,
    parameter logic [3:0] TYPE_NIBBLE   = 4'b1011,
    parameter int         LOCK_ADDR_BIT = 10,
    parameter int         LOCK_DATA_BIT = 1
) (
    input  logic       clk_i,
    input  logic       rst_ni,
    input  logic [2:0] chip_sel_i,
    input  logic       wp_i,
    input  logic       start_i,
    input  logic       stop_i,
    input  logic       byte_vld_i,
    input  logic [7:0] byte_i,
    input  logic       rd_req_i,
    output logic       ack_vld_o,
    output logic       ack_o,
    output logic       rd_vld_o,
    output logic [7:0] rd_data_o
);

    localparam int PTR_W = $clog2(PAGE_BYTES);

    logic             mem_we;
    logic             mem_rd;
    logic [PTR_W-1:0] ptr;

    idp_cmd_fsm #(
        .PAGE_BYTES   (PAGE_BYTES),
        .TYPE_NIBBLE  (TYPE_NIBBLE),
        .LOCK_ADDR_BIT(LOCK_ADDR_BIT),
        .LOCK_DATA_BIT(LOCK_DATA_BIT),
        .PTR_W        (PTR_W)
    ) u_fsm (
        .clk_i     (clk_i),
        .rst_ni    (rst_ni),
        .chip_sel_i(chip_sel_i),
        .wp_i      (wp_i),
        .start_i   (start_i),
        .stop_i    (stop_i),
        .byte_vld_i(byte_vld_i),
        .byte_i    (byte_i),
        .rd_req_i  (rd_req_i),
        .ack_vld_o (ack_vld_o),
        .ack_o     (ack_o),
        .mem_we_o  (mem_we),
        .mem_rd_o  (mem_rd),
        .ptr_o     (ptr)
    );

    idp_page_store #(
        .PAGE_BYTES(PAGE_BYTES),
        .PTR_W     (PTR_W)
    ) u_store (
        .clk_i    (clk_i),
        .rst_ni   (rst_ni),
        .we_i     (mem_we),
        .rd_en_i  (mem_rd),
        .addr_i   (ptr),
        .wdata_i  (byte_i),
        .rd_vld_o (rd_vld_o),
        .rd_data_o(rd_data_o)
    );

endmodule

// File: tb/tb_idpage_ctrl.sv
module tb_idpage_ctrl;

    localparam int CLK_PERIOD = 10;
    localparam logic [2:0] SEL = 3'b101;
    localparam logic [7:0] DEV_W = {4'b1011, SEL, 1'b0};
    localparam logic [7:0] DEV_R = {4'b1011, SEL, 1'b1};

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       wp = 1'b0;
    logic       start = 1'b0, stop = 1'b0, bvld = 1'b0, rreq = 1'b0;
    logic [7:0] bdat = '0;
    logic       ack_vld, ack, rd_vld;
    logic [7:0] rd_data;

    int total = 0;
    int bad   = 0;
    int cyc   = 0;
    bit run   = 1'b0;

    logic  ack_exp_q[$];
    string ack_tag_q[$];
    logic [7:0] rd_exp_q[$];
    string rd_tag_q[$];

    always #(CLK_PERIOD/2) clk = ~clk;

    idpage_ctrl dut (
        .clk_i(clk), .rst_ni(rst_n), .chip_sel_i(SEL), .wp_i(wp),
        .start_i(start), .stop_i(stop), .byte_vld_i(bvld), .byte_i(bdat),
        .rd_req_i(rreq), .ack_vld_o(ack_vld), .ack_o(ack),
        .rd_vld_o(rd_vld), .rd_data_o(rd_data)
    );

    task automatic chk(input bit ok, input string tag, input int act, input int exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    // monitor: pops expectations as results appear
    always @(negedge clk) begin
        cyc++;
        if (run && ack_vld) begin
            if (ack_exp_q.size() == 0) chk(1'b0, "R2 unexpected ack pulse", 1, 0);
            else begin
                logic  e;
                string t;
                e = ack_exp_q.pop_front();
                t = ack_tag_q.pop_front();
                chk(ack == e, t, int'(ack), int'(e));
            end
        end
        if (run && rd_vld) begin
            if (rd_exp_q.size() == 0) chk(1'b0, "R10 unexpected read data", 1, 0);
            else begin
                logic [7:0] e;
                string      t;
                e = rd_exp_q.pop_front();
                t = rd_tag_q.pop_front();
                chk(rd_data == e, t, int'(rd_data), int'(e));
            end
        end
        if (cyc == 100000) begin
            bad++;
            total++;
            $display("FAIL watchdog (R2) actual=hung expected=done");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    task automatic idle();
        @(negedge clk);
    endtask

    task automatic ev_start();
        @(negedge clk); start = 1'b1;
        @(negedge clk); start = 1'b0;
    endtask

    task automatic ev_stop();
        @(negedge clk); stop = 1'b1;
        @(negedge clk); stop = 1'b0;
    endtask

    task automatic put(input logic [7:0] b, input logic exp, input string tag);
        ack_exp_q.push_back(exp);
        ack_tag_q.push_back(tag);
        @(negedge clk); bvld = 1'b1; bdat = b;
        @(negedge clk); bvld = 1'b0;
    endtask

    task automatic get(input logic [7:0] exp, input string tag);
        rd_exp_q.push_back(exp);
        rd_tag_q.push_back(tag);
        @(negedge clk); rreq = 1'b1;
        @(negedge clk); rreq = 1'b0;
    endtask

    // dummy write to set pointer, then repeated Start into a read
    task automatic seek_read(input logic [7:0] lo);
        ev_start();
        put(DEV_W, 1'b1, "R2 device write");
        put(8'h00, 1'b1, "R3 addr hi");
        put(lo,    1'b1, "R3 addr lo");
        ev_start();
        put(DEV_R, 1'b1, "R2 device read");
    endtask

    // lock-form command up to its data byte
    task automatic lock_form(input logic [7:0] data, input logic exp, input string tag);
        ev_start();
        put(DEV_W, 1'b1, "R2 device write");
        put(8'h04, 1'b1, "R3 addr hi bit10");
        put(8'h00, 1'b1, "R3 addr lo");
        put(data, exp, tag);
    endtask

    initial begin
        repeat (3) idle();
        rst_n = 1'b1;
        idle();
        run = 1'b1;
        chk(ack_vld == 1'b0, "R1 ack_vld after reset", int'(ack_vld), 0);
        chk(rd_vld == 1'b0, "R1 rd_vld after reset", int'(rd_vld), 0);

        // current-address read after reset returns zero
        ev_start();
        put(DEV_R, 1'b1, "R2 device read");
        get(8'h00, "R1 page cleared at reset");
        ev_stop();

        // wrong type and wrong chip select: refused, rest ignored
        ev_start();
        put({4'b1010, SEL, 1'b0}, 1'b0, "R2 wrong type");
        put(8'h00, 1'b0, "R2 ignored after wrong type");
        ev_stop();
        ev_start();
        put({4'b1011, 3'b011, 1'b0}, 1'b0, "R2 wrong select");
        put(8'h00, 1'b0, "R2 ignored after wrong select");
        ev_stop();

        // page write at 0x7E with garbage upper address bits, wraps
        ev_start();
        put(DEV_W, 1'b1, "R2 device write");
        put(8'hFB, 1'b1, "R3 hi ignored bits");
        put(8'hFE, 1'b1, "R3 lo bit7 ignored");
        put(8'h11, 1'b1, "R4 data 7E");
        put(8'h22, 1'b1, "R4 data 7F");
        put(8'h33, 1'b1, "R4 data wraps to 00");
        ev_stop();

        // random read across the wrap
        seek_read(8'h7E);
        get(8'h11, "R5 read 7E");
        get(8'h22, "R5 read 7F");
        get(8'h33, "R4 wrapped byte at 00");
        get(8'h00, "R5 read 01");
        ev_stop();

        // read request outside a read transaction
        @(negedge clk); rreq = 1'b1;
        @(negedge clk); rreq = 1'b0;
        chk(rd_vld == 1'b0, "R10 no read outside transaction", int'(rd_vld), 0);
        idle();

        // write-protect: data acked, not stored
        wp = 1'b1;
        ev_start();
        put(DEV_W, 1'b1, "R2 device write");
        put(8'h00, 1'b1, "R3 addr hi");
        put(8'h10, 1'b1, "R3 addr lo");
        put(8'h5A, 1'b1, "R9 ack under wp");
        ev_stop();
        wp = 1'b0;
        seek_read(8'h10);
        get(8'h00, "R9 not stored under wp");
        ev_stop();

        // lock under write-protect has no effect
        wp = 1'b1;
        lock_form(8'hFE, 1'b1, "R6 lock data unlocked");
        ev_stop();
        wp = 1'b0;
        lock_form(8'h02, 1'b1, "R9 still unlocked after wp lock");
        ev_start(); ev_stop();

        // lock data with bit 1 clear is ignored
        lock_form(8'hFD, 1'b1, "R6 lock data unlocked");
        ev_stop();
        lock_form(8'h02, 1'b1, "R7 bit1 clear did not lock");
        ev_start(); ev_stop();
        // the previous query was discarded by Start
        lock_form(8'h02, 1'b1, "R7 start discards query");
        ev_start(); ev_stop();

        // real lock: any bits but bit 1 ignored, extra byte refused
        lock_form(8'hFE, 1'b1, "R6 lock data unlocked");
        put(8'h55, 1'b0, "R6 extra byte refused");
        ev_stop();
        lock_form(8'h02, 1'b0, "R6 query refused when locked");
        ev_start(); ev_stop();

        // writes refused once locked, contents unchanged
        ev_start();
        put(DEV_W, 1'b1, "R2 device write");
        put(8'h00, 1'b1, "R3 addr hi");
        put(8'h7E, 1'b1, "R3 addr lo");
        put(8'h99, 1'b0, "R8 locked data refused");
        put(8'h98, 1'b0, "R8 locked data refused");
        ev_stop();
        seek_read(8'h7E);
        get(8'h11, "R8 contents unchanged");
        ev_stop();

        repeat (5) idle();
        chk(ack_exp_q.size() == 0, "R2 all acks seen", ack_exp_q.size(), 0);
        chk(rd_exp_q.size() == 0, "R5 all reads seen", rd_exp_q.size(), 0);
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule